// File: doc/BRIEF.md
# Dual-channel UART control front end

This block is the host-side register and clocking front end for a pair of identical UART channels. A processor reaches it over an 8-bit parallel bus. The bus has a 3-bit register offset, an active-low chip select, active-low read and write strobes, and a channel-select bit that picks channel A (0) or channel B (1). Each channel keeps a line register, a modem register and a 16-bit divisor split into low and high bytes. Each channel also runs a baud generator that counts reference ticks.

A single alternate register is shared by both channels. It can turn on broadcast writes, so that one host write lands in both channels' per-channel registers. It also chooses what drives each channel's active-low multi-function pin: the inverted modem OP2 bit, the baud pulse, or the inverted receive-ready input. The 16x reference arrives as a one-cycle enable pulse on `ref16_en`, and the baud output is a one-cycle pulse.

Top module: `dual_uart_front`

## Requirements
- R1: Reset is synchronous and active high. It clears every register to 0, drives `bus_rdata` to 0x00 and drives both `mf_n` bits high.
- R2: A register write happens once, on the first clock where chip select and write strobe are both low. Read data is registered: it is valid one clock after chip select and read strobe go low, and it is 0x00 in any cycle that follows a clock without an active read.
- R3: Offset 3 holds the line register and offset 4 holds the modem register. Offsets 0 and 1 reach the divisor low and high bytes only while bit 7 of the addressed channel's line register is 1. Otherwise, writes to those offsets are ignored and reads of them return 0x00. Offsets 5 to 7 read 0x00.
- R4: Offset 2 reaches the shared alternate register only while the addressed channel's line register equals 0xBF. Otherwise, writes to it are ignored and reads return 0x00. Only bits 2:0 are stored, and the upper bits read 0.
- R5: While alternate bit 0 is 1, a write to offset 0, 1, 3 or 4 updates that register in both channels. Divisor access is decided by the addressed channel's line register.
- R6: Alternate bits 2:1 = 00 selects OP2 mode. In this mode `mf_n[c]` is the inverse of bit 3 of channel c's modem register, one clock later.
- R7: Alternate bits 2:1 = 01 selects baud mode. In this mode `mf_n[c]` goes low for one clock once every N reference ticks, where N = {high byte, low byte} is the divisor. A divisor of 1 gives one pulse per reference tick.
- R8: A divisor of 0 produces no baud pulses, so in baud mode the pin stays high.
- R9: Alternate bits 2:1 = 10 or 11 selects receive-ready mode. In this mode `mf_n[c]` is the inverse of `rx_ready[c]`, one clock later.
- R10: Writing either divisor byte restarts that channel's generator. The first pulse after a restart comes on the first reference tick after the write, not at the end of the old period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 3 | Register offset |
| bus_chan_sel | input | 1 | Channel select (0 = A, 1 = B) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ref16_en | input | 1 | 16x reference tick, one-cycle enable |
| rx_ready | input | 2 | Receive-ready status per channel, active high |
| mf_n | output | 2 | Multi-function output per channel, active low |

## Verification
Baud mode is tried with several divisors: 1 (pass-through), 3, 96, 384 and random small values. Measuring the pulse period on both channels separates a correct divide-by-N from off-by-one reload errors and from the high byte being ignored. A zero divisor and a mid-period rewrite of the divisor separate the stop case and the restart case from free-running counting. Register traffic runs as a seeded random mix of offsets, channels, data and gating line values, checked against a bench model. This mix exposes wrong gating, a missing broadcast and an errant channel select. Directed OP2 and receive-ready patterns, with the two channels set differently, show that each pin follows its own channel.

// File: rtl/dual_uart_front_pkg.sv
package dual_uart_front_pkg;
  localparam logic [2:0] OFS_DIV_LO = 3'd0;
  localparam logic [2:0] OFS_DIV_HI = 3'd1;
  localparam logic [2:0] OFS_ALT    = 3'd2;
  localparam logic [2:0] OFS_LINE   = 3'd3;
  localparam logic [2:0] OFS_MODEM  = 3'd4;

  localparam int ALT_W        = 3;
  localparam int ALT_BCAST    = 0;
  localparam int MODEM_OP2    = 3;
  localparam logic [7:0] ALT_KEY = 8'hBF;

  typedef enum logic [1:0] {
    MF_OP2   = 2'b00,
    MF_BAUD  = 2'b01,
    MF_RXRDY = 2'b10,
    MF_RXRD2 = 2'b11
  } mf_sel_e;
endpackage

// File: rtl/dual_uart_front_host.sv
module dual_uart_front_host
  import dual_uart_front_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic [DATA_W-1:0] line_sel,
  input  logic              bcast,
  output logic              wr_stb,
  output logic [NCH-1:0]    we_div_lo,
  output logic [NCH-1:0]    we_div_hi,
  output logic [NCH-1:0]    we_line,
  output logic [NCH-1:0]    we_modem,
  output logic              we_alt
);
  logic           wr_act;
  logic           wr_act_q;
  logic           div_open;
  logic           key_open;
  logic [NCH-1:0] mask;

  assign wr_act = ~cs_n & ~wr_n;

  always_ff @(posedge clk) begin
    if (rst) wr_act_q <= 1'b0;
    else     wr_act_q <= wr_act;
  end

  assign wr_stb   = wr_act & ~wr_act_q;
  assign div_open = line_sel[DATA_W-1];
  assign key_open = (line_sel == DATA_W'(ALT_KEY));
  assign mask     = bcast ? {NCH{1'b1}} : (NCH'(1) << chan_sel);

  always_comb begin
    we_div_lo = '0;
    we_div_hi = '0;
    we_line   = '0;
    we_modem  = '0;
    we_alt    = 1'b0;
    if (wr_stb) begin
      case (addr)
        ADDR_W'(OFS_DIV_LO): if (div_open) we_div_lo = mask;
        ADDR_W'(OFS_DIV_HI): if (div_open) we_div_hi = mask;
        ADDR_W'(OFS_ALT):    we_alt = key_open;
        ADDR_W'(OFS_LINE):   we_line = mask;
        ADDR_W'(OFS_MODEM):  we_modem = mask;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dual_uart_front_chan.sv
module dual_uart_front_chan #(
  parameter int DATA_W = 8,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_div_lo,
  input  logic              we_div_hi,
  input  logic              we_line,
  input  logic              we_modem,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] line_q,
  output logic [DATA_W-1:0] modem_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              restart_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q    <= '0;
      modem_q   <= '0;
      div_q     <= '0;
      restart_q <= 1'b0;
    end else begin
      if (we_line)   line_q  <= wdata;
      if (we_modem)  modem_q <= wdata;
      if (we_div_lo) div_q[DATA_W-1:0]     <= wdata;
      if (we_div_hi) div_q[DIV_W-1:DATA_W] <= wdata;
      restart_q <= we_div_lo | we_div_hi;
    end
  end
endmodule

// File: rtl/dual_uart_front_baud.sv
module dual_uart_front_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (restart) begin
      cnt  <= (div != '0) ? DIV_W'(1) : '0;
      tick <= 1'b0;
    end else if (ref_en) begin
      if (cnt == DIV_W'(1)) begin
        tick <= 1'b1;
        cnt  <= div;
      end else begin
        tick <= 1'b0;
        if (cnt != '0) cnt <= cnt - 1'b1;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_uart_front.sv
module dual_uart_front
  import dual_uart_front_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CH_W-1:0]   bus_chan_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref16_en,
  input  logic [NCH-1:0]    rx_ready,
  output logic [NCH-1:0]    mf_n
);
  logic [NCH-1:0][DATA_W-1:0] line_q;
  logic [NCH-1:0][DATA_W-1:0] modem_q;
  logic [NCH-1:0][DIV_W-1:0]  div_q;
  logic [NCH-1:0]             restart;
  logic [NCH-1:0]             baud_tick;
  logic [NCH-1:0]             we_div_lo, we_div_hi, we_line, we_modem;
  logic                       we_alt;
  logic                       wr_stb;
  logic [ALT_W-1:0]           afr_q;
  logic [DATA_W-1:0]          line_sel;
  logic [DATA_W-1:0]          rd_val;
  mf_sel_e                    mf_sel;

  assign line_sel = line_q[bus_chan_sel];
  assign mf_sel   = mf_sel_e'(afr_q[2:1]);

  dual_uart_front_host #(
    .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W)
  ) i_host (
    .clk(clk), .rst(rst), .cs_n(bus_cs_n), .wr_n(bus_wr_n),
    .addr(bus_addr), .chan_sel(bus_chan_sel), .line_sel(line_sel),
    .bcast(afr_q[ALT_BCAST]), .wr_stb(wr_stb),
    .we_div_lo(we_div_lo), .we_div_hi(we_div_hi),
    .we_line(we_line), .we_modem(we_modem), .we_alt(we_alt)
  );

  always_ff @(posedge clk) begin
    if (rst)         afr_q <= '0;
    else if (we_alt) afr_q <= bus_wdata[ALT_W-1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dual_uart_front_chan #(.DATA_W(DATA_W)) i_chan (
      .clk(clk), .rst(rst),
      .we_div_lo(we_div_lo[g]), .we_div_hi(we_div_hi[g]),
      .we_line(we_line[g]), .we_modem(we_modem[g]),
      .wdata(bus_wdata),
      .line_q(line_q[g]), .modem_q(modem_q[g]),
      .div_q(div_q[g]), .restart_q(restart[g])
    );

    dual_uart_front_baud #(.DIV_W(DIV_W)) i_baud (
      .clk(clk), .rst(rst), .ref_en(ref16_en),
      .restart(restart[g]), .div(div_q[g]), .tick(baud_tick[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        mf_n[g] <= 1'b1;
      end else begin
        case (mf_sel)
          MF_OP2:  mf_n[g] <= ~modem_q[g][MODEM_OP2];
          MF_BAUD: mf_n[g] <= ~baud_tick[g];
          default: mf_n[g] <= ~rx_ready[g];
        endcase
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      ADDR_W'(OFS_DIV_LO): if (line_sel[DATA_W-1]) rd_val = div_q[bus_chan_sel][DATA_W-1:0];
      ADDR_W'(OFS_DIV_HI): if (line_sel[DATA_W-1]) rd_val = div_q[bus_chan_sel][DIV_W-1:DATA_W];
      ADDR_W'(OFS_ALT):    if (line_sel == DATA_W'(ALT_KEY)) rd_val = DATA_W'(afr_q);
      ADDR_W'(OFS_LINE):   rd_val = line_sel;
      ADDR_W'(OFS_MODEM):  rd_val = modem_q[bus_chan_sel];
      default:             rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                      bus_rdata <= '0;
    else if (~bus_cs_n & ~bus_rd_n) bus_rdata <= rd_val;
    else                          bus_rdata <= '0;
  end
endmodule

// File: rtl/dual_uart_front_chk.sv
module dual_uart_front_chk #(
  parameter int NCH    = 2,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int DIV_W = 2 * DATA_W
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_cs_n,
  input logic                       bus_rd_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [NCH-1:0]             rx_ready,
  input logic [NCH-1:0]             mf_n,
  input logic                       wr_stb,
  input logic [2:0]                 afr_q,
  input logic [NCH-1:0][DATA_W-1:0] modem_q,
  input logic [NCH-1:0][DIV_W-1:0]  div_q,
  input logic [NCH-1:0]             baud_tick
);
  assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (rst)
    !(!bus_cs_n && !bus_rd_n) |=> (bus_rdata == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    assert_op2_follow_R6: assert property (@(posedge clk) disable iff (rst)
      (afr_q[2:1] == 2'b00) |=> (mf_n[c] == !$past(modem_q[c][3])));

    assert_rxrdy_follow_R9: assert property (@(posedge clk) disable iff (rst)
      afr_q[2] |=> (mf_n[c] == !$past(rx_ready[c])));

    assert_zero_div_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      (div_q[c] == '0 && $past(div_q[c]) == '0) |=> !baud_tick[c]);

    if (c > 0) begin : g_b
      assert_bcast_modem_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && afr_q[0] && bus_addr == ADDR_W'(4)) |=> (modem_q[c] == modem_q[0]));
    end
  end
endmodule

bind dual_uart_front dual_uart_front_chk #(
  .NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .rx_ready(rx_ready),
  .mf_n(mf_n), .wr_stb(wr_stb), .afr_q(afr_q), .modem_q(modem_q),
  .div_q(div_q), .baud_tick(baud_tick)
);

// File: tb/test_dual_uart_front.sv
module test_dual_uart_front;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [0:0] bus_chan_sel = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ref16_en = 1'b0;
  logic [1:0] rx_ready = '0;
  logic [1:0] mf_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_line[2], m_modem[2], m_dlo[2], m_dhi[2];
  logic [2:0] m_alt;

  always #5 clk = ~clk;

  always @(negedge clk) ref16_en <= rst ? 1'b0 : ~ref16_en;

  dual_uart_front i_dual_uart_front (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_chan_sel(bus_chan_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref16_en(ref16_en),
    .rx_ready(rx_ready), .mf_n(mf_n)
  );

  function automatic void model_reset();
    for (int c = 0; c < 2; c++) begin
      m_line[c] = 0; m_modem[c] = 0; m_dlo[c] = 0; m_dhi[c] = 0;
    end
    m_alt = 0;
  endfunction

  function automatic void model_write(int ch, int a, logic [7:0] d);
    bit dl  = m_line[ch][7];
    bit key = (m_line[ch] == 8'hBF);
    bit bc  = m_alt[0];
    for (int c = 0; c < 2; c++) begin
      if (c == ch || bc) begin
        case (a)
          0: if (dl) m_dlo[c] = d;
          1: if (dl) m_dhi[c] = d;
          3: m_line[c] = d;
          4: m_modem[c] = d;
          default: ;
        endcase
      end
    end
    if (a == 2 && key) m_alt = d[2:0];
  endfunction

  function automatic logic [7:0] model_read(int ch, int a);
    case (a)
      0: return m_line[ch][7] ? m_dlo[ch] : 8'h00;
      1: return m_line[ch][7] ? m_dhi[ch] : 8'h00;
      2: return (m_line[ch] == 8'hBF) ? {5'b0, m_alt} : 8'h00;
      3: return m_line[ch];
      4: return m_modem[ch];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(int ch, int a, logic [7:0] d);
    @(negedge clk);
    bus_chan_sel = 1'(ch); bus_addr = 3'(a); bus_wdata = d;
    bus_cs_n = 0; bus_wr_n = 0;
    @(negedge clk);
    bus_cs_n = 1; bus_wr_n = 1;
    model_write(ch, a, d);
  endtask

  task automatic rd(int ch, int a, output logic [7:0] d);
    @(negedge clk);
    bus_chan_sel = 1'(ch); bus_addr = 3'(a);
    bus_cs_n = 0; bus_rd_n = 0;
    @(negedge clk);
    d = bus_rdata;
    bus_cs_n = 1; bus_rd_n = 1;
  endtask

  task automatic check_rd(int ch, int a, string req);
    logic [7:0] d;
    rd(ch, a, d);
    chk(d == model_read(ch, a), req, d, model_read(ch, a));
  endtask

  task automatic set_div(int ch, int dv);
    wr(ch, 3, 8'h80);
    wr(ch, 0, 8'(dv));
    wr(ch, 1, 8'(dv >> 8));
  endtask

  task automatic set_alt(int ch, logic [7:0] v);
    wr(ch, 3, 8'hBF);
    wr(ch, 2, v);
  endtask

  task automatic find_fall(int ch, int limit, output int waited);
    bit prev = mf_n[ch];
    waited = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (prev && !mf_n[ch]) begin
        waited = i + 1;
        break;
      end
      prev = mf_n[ch];
    end
  endtask

  task automatic check_period(int ch, int dv, string req);
    int w;
    find_fall(ch, 4 * dv + 20, w);
    find_fall(ch, 4 * dv + 20, w);
    chk(w == 2 * dv, req, w, 2 * dv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int w, lows;
    int divs[6];
    void'($urandom(32'd4711));
    model_reset();
    repeat (5) @(negedge clk);
    rst = 0;

    // R1: reset state
    @(negedge clk);
    chk(bus_rdata == 8'h00, "R1 rdata", bus_rdata, 0);
    chk(mf_n == 2'b11, "R1 mf_n", mf_n, 3);
    check_rd(0, 3, "R1 line A");
    check_rd(1, 4, "R1 modem B");

    // R2: read data returns to zero after the read
    wr(0, 3, 8'h1B);
    check_rd(0, 3, "R2 readback");
    @(negedge clk);
    chk(bus_rdata == 8'h00, "R2 idle zero", bus_rdata, 0);

    // R3: divisor gating
    wr(0, 3, 8'h03);
    wr(0, 0, 8'h55);
    check_rd(0, 0, "R3 closed read");
    wr(0, 3, 8'h83);
    check_rd(0, 0, "R3 ignored write");
    wr(0, 0, 8'hA5); wr(0, 1, 8'h3C);
    check_rd(0, 0, "R3 div lo");
    check_rd(0, 1, "R3 div hi");
    check_rd(0, 6, "R3 reserved");
    check_rd(1, 0, "R3 channel B untouched");

    // R4: alternate register behind key
    wr(0, 2, 8'hFF);
    wr(0, 3, 8'hBF);
    check_rd(0, 2, "R4 ignored without key");
    wr(0, 2, 8'hF8);
    check_rd(0, 2, "R4 upper bits zero");
    wr(1, 3, 8'h80);
    check_rd(1, 2, "R4 other channel closed");

    // R5: broadcast writes
    set_alt(0, 8'h01);
    wr(0, 4, 8'h5A);
    check_rd(0, 4, "R5 modem A");
    check_rd(1, 4, "R5 modem B");
    wr(1, 3, 8'hBF);
    check_rd(0, 3, "R5 line A");
    wr(0, 0, 8'h21);
    check_rd(1, 0, "R5 div lo B");
    set_alt(0, 8'h00);

    // R6: OP2 mode
    wr(0, 4, 8'h08); wr(1, 4, 8'h00);
    @(negedge clk); @(negedge clk);
    chk(mf_n == 2'b10, "R6 op2 A only", mf_n, 2);
    wr(1, 4, 8'hFF); wr(0, 4, 8'hF7);
    @(negedge clk); @(negedge clk);
    chk(mf_n == 2'b01, "R6 op2 B only", mf_n, 1);

    // R9: receive-ready mode, both codes
    rx_ready = 2'b01;
    set_alt(0, 8'h04);
    @(negedge clk); @(negedge clk);
    chk(mf_n == 2'b10, "R9 code 10", mf_n, 2);
    set_alt(0, 8'h06);
    rx_ready = 2'b10;
    @(negedge clk); @(negedge clk);
    chk(mf_n == 2'b01, "R9 code 11", mf_n, 1);

    // R7: baud periods (reference tick every 2 clocks)
    divs[0] = 1; divs[1] = 3; divs[2] = 96; divs[3] = 384;
    divs[4] = $urandom_range(2, 40); divs[5] = $urandom_range(2, 40);
    foreach (divs[i]) begin
      set_div(0, divs[i]);
      set_alt(0, 8'h02);
      check_period(0, divs[i], "R7 period A");
    end
    set_div(1, 5);
    set_alt(1, 8'h02);
    check_period(1, 5, "R7 period B");

    // R10: restart on divisor write
    set_div(0, 400);
    set_alt(0, 8'h02);
    find_fall(0, 1700, w);
    repeat (50) @(negedge clk);
    wr(0, 0, 8'h90);
    find_fall(0, 10, w);
    chk(w > 0 && w <= 8, "R10 restart", w, 5);

    // R8: zero divisor gives no pulses
    set_div(0, 0);
    set_alt(0, 8'h02);
    lows = 0;
    repeat (200) begin
      @(negedge clk);
      if (!mf_n[0]) lows++;
    end
    chk(lows == 0, "R8 zero divisor", lows, 0);

    // R3 R4 R5: random register traffic against the model
    for (int k = 0; k < 200; k++) begin
      int ch = $urandom_range(0, 1);
      int a  = $urandom_range(0, 4);
      logic [7:0] dv = 8'($urandom);
      if (a == 3 && $urandom_range(0, 2) == 0) dv = ($urandom_range(0, 1) == 0) ? 8'hBF : 8'h80;
      wr(ch, a, dv);
      check_rd($urandom_range(0, 1), $urandom_range(0, 5), "R3/R4/R5 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule